// File: doc/BRIEF.md
# Vector length configuration unit

This unit carries out the arithmetic behind the three instructions that set up vector length: the register form, where both the requested element count (AVL) and the type word come from registers, and the two immediate forms, where either the type word or the AVL is an immediate. The caller supplies the variant, the AVL, the proposed type word, flags saying whether the rs1 and rd specifiers are register zero, and the current type word and length. The unit checks the proposed type word, works out the largest element count the setting allows (VLMAX), and chooses the new length.

The type word uses these bit positions: group multiplier code in bits [2:0], element width code in bits [5:3], tail-agnostic flag in bit 6, mask-agnostic flag in bit 7, and the illegal flag (vill) in bit XLEN-1. The element width is SEW = 8 << code[1:0]. Multiplier codes 000/001/010/011 mean LMUL 1/2/4/8, and codes 101/110/111 mean 1/8, 1/4 and 1/2. The variant code on `opI` is 1 for the immediate-type form and 2 for the immediate-AVL form. Any other value selects the register form.

A request pulsed on `startI` produces its result one clock later. The result is the new type word, the new length, the value to write to rd, and a strobe that tells the CSR file to clear the vector start index. The CSR storage and the instruction decode sit outside this block.

Top module: `vcfg_top`

## Requirements
- R1: After reset, `validO` and `vstartClrO` are 0, `vtypeO` has only bit XLEN-1 set, and `vlO` and `rdDataO` are 0.
- R2: A request sampled with `startI` high at a clock edge drives `validO` and `vstartClrO` high for that one following cycle only. Without a request, `validO` is 0 and `vtypeO` and `vlO` hold their values.
- R3: The proposed word is illegal if any of these holds: bit XLEN-1 is set, bit 5 is set, bits [2:0] equal 100, or (with XLEN = 32) bits [2:0] equal 101. An illegal word gives `vtypeO` with only bit XLEN-1 set and `vlO` = 0.
- R4: A setting where SEW > LMUL × ELEN is unsupported and gives the same output as R3.
- R5: A legal, supported word gives `vtypeO` with bit XLEN-1 clear, bits [7:0] copied from the proposed word, and every other bit 0.
- R6: With VLMAX = VLEN × LMUL / SEW, an AVL below VLMAX gives `vlO` = AVL, and an AVL of at least 2 × VLMAX gives `vlO` = VLMAX.
- R7: For VLMAX ≤ AVL < 2 × VLMAX, `vlO` is ceil(AVL/2) when parameter HALF_POLICY is 1 (the default), and VLMAX when it is 0.
- R8: In the register and immediate-type forms, with rs1 zero and rd not zero, `vlO` = VLMAX whatever `avlI` holds.
- R9: In the register and immediate-type forms, with both rs1 and rd zero: if the current word has bit XLEN-1 clear and the same SEW/LMUL ratio as the new word, `vlO` = `curVlI` and the new word is taken. Otherwise the output is as in R3.
- R10: In the immediate-AVL form, the rs1-zero and rd-zero flags have no effect, and `vlO` follows R6/R7 from `avlI`.
- R11: In both immediate forms, only bits [10:0] of `vtypeI` are used. Higher bits, bit XLEN-1 included, have no effect.
- R12: `rdDataO` equals `vlO` zero-extended to XLEN bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startI | input | 1 | Request strobe |
| opI | input | 2 | Variant: 1 immediate-type, 2 immediate-AVL, other register form |
| avlI | input | XLEN | Requested element count |
| vtypeI | input | XLEN | Proposed type word |
| rs1ZeroI | input | 1 | rs1 specifier is register zero |
| rdZeroI | input | 1 | rd specifier is register zero |
| curVtypeI | input | XLEN | Current type word |
| curVlI | input | clog2(VLEN)+1 | Current length |
| validO | output | 1 | Result valid, one cycle |
| vtypeO | output | XLEN | New type word |
| vlO | output | clog2(VLEN)+1 | New length |
| rdDataO | output | XLEN | Value for rd |
| vstartClrO | output | 1 | Clear the start index |

## Verification
The bench sweeps all 256 values of the low type byte in the register form. For each value it applies the AVLs around 0, VLMAX and 2 × VLMAX, plus the all-ones value. This separates the plain, halved and clamped length regions, and it separates legal settings from reserved and unsupported ones. A second instance built with the VLMAX policy gets the same inputs, which shows that the mid-range policy alone changes the result. Further patterns cover the following: rs1 zero with rd nonzero; the keep-length case against current words with matching ratio, differing ratio and vill set; the immediate forms with high garbage bits; and the immediate-AVL form with both zero flags set.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef enum logic [1:0] {
    OP_REG     = 2'd0,
    OP_IMMTYPE = 2'd1,
    OP_IMMAVL  = 2'd2,
    OP_ALT     = 2'd3
  } cfgOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic forceVill;
    logic selKeep;
    logic selMax;
  } cfgStrobe_t;

  // log2 of the group multiplier, signed; reserved code maps to 0
  function automatic int lmulLog(input logic [2:0] code);
    case (code)
      3'b000:  return 0;
      3'b001:  return 1;
      3'b010:  return 2;
      3'b011:  return 3;
      3'b101:  return -3;
      3'b110:  return -2;
      3'b111:  return -1;
      default: return 0;
    endcase
  endfunction

  // log2 of the element width in bits
  function automatic int sewLog(input logic [1:0] code);
    return 3 + int'(code);
  endfunction

endpackage

// File: rtl/vcfg_ctrl.sv
module vcfg_ctrl
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ELEN = 32
) (
  input  logic            startI,
  input  logic [1:0]      opI,
  input  logic            rs1ZeroI,
  input  logic            rdZeroI,
  input  logic [XLEN-1:0] vtypeI,
  input  logic [XLEN-1:0] curVtypeI,
  output logic [XLEN-1:0] propVtypeO,
  output cfgStrobe_t      strobeO
);
  localparam int ELEN_LOG = $clog2(ELEN);

  logic immType;
  logic hasRs1;
  logic reservedEnc;
  logic unsupported;
  logic ratioMatch;
  logic keepMode;
  logic maxMode;
  logic unusedCur;
  int   newSew;
  int   newLmul;
  int   curSew;
  int   curLmul;

  assign immType = (opI == OP_IMMTYPE) || (opI == OP_IMMAVL);
  assign hasRs1  = (opI != OP_IMMAVL);
  assign propVtypeO = immType ? {{(XLEN-11){1'b0}}, vtypeI[10:0]} : vtypeI;

  always_comb begin
    newSew  = sewLog(propVtypeO[4:3]);
    newLmul = lmulLog(propVtypeO[2:0]);
    curSew  = sewLog(curVtypeI[4:3]);
    curLmul = lmulLog(curVtypeI[2:0]);
    reservedEnc = propVtypeO[XLEN-1] || propVtypeO[5] ||
                  (propVtypeO[2:0] == 3'b100) ||
                  ((XLEN == 32) && (propVtypeO[2:0] == 3'b101));
    unsupported = newSew > (newLmul + ELEN_LOG);
    ratioMatch  = !curVtypeI[XLEN-1] && ((newSew - newLmul) == (curSew - curLmul));
  end

  assign keepMode = hasRs1 && rs1ZeroI && rdZeroI;
  assign maxMode  = hasRs1 && rs1ZeroI && !rdZeroI;

  assign strobeO.capture   = startI;
  assign strobeO.forceVill = reservedEnc || unsupported || (keepMode && !ratioMatch);
  assign strobeO.selKeep   = keepMode;
  assign strobeO.selMax    = maxMode;

  assign unusedCur = ^{curVtypeI[XLEN-2:5]};

endmodule

// File: rtl/vcfg_dp.sv
module vcfg_dp
  import vcfg_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int VLEN        = 128,
  parameter bit HALF_POLICY = 1'b1,
  parameter int VLW         = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  cfgStrobe_t      strobeI,
  input  logic [XLEN-1:0] propVtypeI,
  input  logic [XLEN-1:0] avlI,
  input  logic [VLW-1:0]  curVlI,
  output logic            validO,
  output logic [XLEN-1:0] vtypeO,
  output logic [VLW-1:0]  vlO
);
  localparam int VLEN_LOG = $clog2(VLEN);
  localparam logic [XLEN-1:0] VILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

  int            vmLog;
  logic [XLEN:0] vlmax;
  logic [XLEN:0] avlExt;
  logic [XLEN:0] halfUp;
  logic [VLW-1:0] ruleVl;
  logic [VLW-1:0] nextVl;
  logic [XLEN-1:0] nextVtype;
  logic unusedProp;

  always_comb begin
    vmLog = VLEN_LOG + lmulLog(propVtypeI[2:0]) - sewLog(propVtypeI[4:3]);
    if (vmLog < 0) vmLog = 0;
    vlmax  = {{XLEN{1'b0}}, 1'b1} << vmLog;
    avlExt = {1'b0, avlI};
    halfUp = (avlExt + 1'b1) >> 1;
    if (avlExt < vlmax)             ruleVl = avlExt[VLW-1:0];
    else if (avlExt < (vlmax << 1)) ruleVl = HALF_POLICY ? halfUp[VLW-1:0] : vlmax[VLW-1:0];
    else                            ruleVl = vlmax[VLW-1:0];

    if (strobeI.forceVill)    nextVl = '0;
    else if (strobeI.selKeep) nextVl = curVlI;
    else if (strobeI.selMax)  nextVl = vlmax[VLW-1:0];
    else                      nextVl = ruleVl;

    nextVtype = strobeI.forceVill ? VILL_WORD : {{(XLEN-8){1'b0}}, propVtypeI[7:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validO <= 1'b0;
      vtypeO <= VILL_WORD;
      vlO    <= '0;
    end else begin
      validO <= strobeI.capture;
      if (strobeI.capture) begin
        vtypeO <= nextVtype;
        vlO    <= nextVl;
      end
    end
  end

  assign unusedProp = ^{propVtypeI[XLEN-1:8]};

endmodule

// File: rtl/vcfg_top.sv
module vcfg_top
  import vcfg_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int VLEN        = 128,
  parameter int ELEN        = 32,
  parameter bit HALF_POLICY = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startI,
  input  logic [1:0]             opI,
  input  logic [XLEN-1:0]        avlI,
  input  logic [XLEN-1:0]        vtypeI,
  input  logic                   rs1ZeroI,
  input  logic                   rdZeroI,
  input  logic [XLEN-1:0]        curVtypeI,
  input  logic [$clog2(VLEN):0]  curVlI,
  output logic                   validO,
  output logic [XLEN-1:0]        vtypeO,
  output logic [$clog2(VLEN):0]  vlO,
  output logic [XLEN-1:0]        rdDataO,
  output logic                   vstartClrO
);
  localparam int VLW = $clog2(VLEN) + 1;

  cfgStrobe_t      strobe;
  logic [XLEN-1:0] propVtype;

  vcfg_ctrl #(.XLEN(XLEN), .ELEN(ELEN)) uCtrl (
    .startI(startI), .opI(opI), .rs1ZeroI(rs1ZeroI), .rdZeroI(rdZeroI),
    .vtypeI(vtypeI), .curVtypeI(curVtypeI),
    .propVtypeO(propVtype), .strobeO(strobe)
  );

  vcfg_dp #(.XLEN(XLEN), .VLEN(VLEN), .HALF_POLICY(HALF_POLICY), .VLW(VLW)) uDp (
    .clk(clk), .rstN(rstN), .strobeI(strobe), .propVtypeI(propVtype),
    .avlI(avlI), .curVlI(curVlI),
    .validO(validO), .vtypeO(vtypeO), .vlO(vlO)
  );

  assign rdDataO    = {{(XLEN-VLW){1'b0}}, vlO};
  assign vstartClrO = validO;

endmodule

// File: rtl/vcfg_chk.sv
module vcfg_chk #(
  parameter int XLEN = 32,
  parameter int VLEN = 128
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  startI,
  input logic [1:0]            opI,
  input logic [XLEN-1:0]       vtypeI,
  input logic                  rs1ZeroI,
  input logic                  rdZeroI,
  input logic                  validO,
  input logic [XLEN-1:0]       vtypeO,
  input logic [$clog2(VLEN):0] vlO,
  input logic [XLEN-1:0]       rdDataO
);
  logic regForm;
  assign regForm = (opI != 2'd1) && (opI != 2'd2);

  assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    startI |=> validO);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !startI |=> (!validO && $stable(vlO) && $stable(vtypeO)));

  assert_vill_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    vtypeO[XLEN-1] |-> (vlO == '0 && vtypeO[XLEN-2:0] == '0));

  assert_top_bit_illegal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startI && regForm && vtypeI[XLEN-1]) |=> vtypeO[XLEN-1]);

  assert_max_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startI && regForm && rs1ZeroI && !rdZeroI) |=> (vlO != '0 || vtypeO[XLEN-1]));

  assert_vl_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    validO |-> (int'(vlO) <= VLEN));

  assert_rd_mirror_R12: assert property (@(posedge clk) disable iff (!rstN)
    validO |-> (rdDataO[$clog2(VLEN):0] == vlO));

endmodule

bind vcfg_top vcfg_chk #(.XLEN(XLEN), .VLEN(VLEN)) uChk (
  .clk(clk), .rstN(rstN), .startI(startI), .opI(opI), .vtypeI(vtypeI),
  .rs1ZeroI(rs1ZeroI), .rdZeroI(rdZeroI), .validO(validO),
  .vtypeO(vtypeO), .vlO(vlO), .rdDataO(rdDataO)
);

// File: tb/sim_vcfg_top.sv
module sim_vcfg_top;
  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int ELEN = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 1'b0;
  logic [1:0] opI = '0;
  logic [31:0] avlI = '0;
  logic [31:0] vtypeI = '0;
  logic rs1ZeroI = 1'b0;
  logic rdZeroI = 1'b0;
  logic [31:0] curVtypeI = '0;
  logic [7:0] curVlI = '0;
  logic validO, vstartClrO, validB, vstartB;
  logic [31:0] vtypeO, rdDataO, vtypeB, rdDataB;
  logic [7:0] vlO, vlB;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vcfg_top #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .HALF_POLICY(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .startI(startI), .opI(opI), .avlI(avlI), .vtypeI(vtypeI),
    .rs1ZeroI(rs1ZeroI), .rdZeroI(rdZeroI), .curVtypeI(curVtypeI), .curVlI(curVlI),
    .validO(validO), .vtypeO(vtypeO), .vlO(vlO), .rdDataO(rdDataO), .vstartClrO(vstartClrO));

  vcfg_top #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .HALF_POLICY(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .startI(startI), .opI(opI), .avlI(avlI), .vtypeI(vtypeI),
    .rs1ZeroI(rs1ZeroI), .rdZeroI(rdZeroI), .curVtypeI(curVtypeI), .curVlI(curVlI),
    .validO(validB), .vtypeO(vtypeB), .vlO(vlB), .rdDataO(rdDataB), .vstartClrO(vstartB));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint vlmaxOf(input logic [31:0] w);
    longint sew = 8 << w[4:3];
    longint num = (w[2]) ? 1 : (1 << w[1:0]);
    longint den = (w[2]) ? (1 << (8 - int'(w[2:0]))) : 1;
    return (VLEN * num) / (den * sew);
  endfunction

  // expected behaviour from the requirements
  task automatic model(input logic [1:0] op, input logic [31:0] vt, input logic [31:0] avl,
                       input logic rs1z, input logic rdz, input logic [31:0] cur,
                       input logic [7:0] curVl, input bit halfPol,
                       output logic [31:0] eVt, output longint eVl, output string tag);
    logic [31:0] w;
    longint sew, num, den, csew, cnum, cden, m, a;
    bit bad, unsup, imm, keep, mx, match, kill;
    imm = (op == 2'd1) || (op == 2'd2);
    w = imm ? (vt & 32'h7ff) : vt;
    bad = w[31] || w[5] || (w[2:0] == 3'b100) || (w[2:0] == 3'b101);
    sew = 8 << w[4:3];
    num = w[2] ? 1 : (1 << w[1:0]);
    den = w[2] ? (1 << (8 - int'(w[2:0]))) : 1;
    unsup = (sew * den) > (num * ELEN);
    csew = 8 << cur[4:3];
    cnum = cur[2] ? 1 : (1 << cur[1:0]);
    cden = cur[2] ? (1 << (8 - int'(cur[2:0]))) : 1;
    match = !cur[31] && (sew * den * cnum == csew * cden * num);
    keep = (op != 2'd2) && rs1z && rdz;
    mx   = (op != 2'd2) && rs1z && !rdz;
    kill = bad || unsup || (keep && !match);
    m = vlmaxOf(w);
    a = longint'(avl);
    if (kill) begin
      eVt = 32'h8000_0000; eVl = 0;
      tag = bad ? "R3" : (unsup ? "R4" : "R9");
    end else begin
      eVt = {24'h0, w[7:0]};
      if (keep) begin eVl = curVl; tag = "R9"; end
      else if (mx) begin eVl = m; tag = "R8"; end
      else if (a < m) begin eVl = a; tag = (op == 2'd2) ? "R10" : "R6"; end
      else if (a < 2 * m) begin eVl = halfPol ? (a + 1) / 2 : m; tag = "R7"; end
      else begin eVl = m; tag = (op == 2'd2) ? "R10" : "R6"; end
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [31:0] vt, input logic [31:0] avl,
                       input logic rs1z, input logic rdz, input logic [31:0] cur,
                       input logic [7:0] curVl);
    logic [31:0] eVt, eVtB;
    longint eVl, eVlB;
    string tag, tagB, vtTag;
    logic [7:0] heldVl;
    model(op, vt, avl, rs1z, rdz, cur, curVl, 1'b1, eVt, eVl, tag);
    model(op, vt, avl, rs1z, rdz, cur, curVl, 1'b0, eVtB, eVlB, tagB);
    vtTag = (tag == "R3" || tag == "R4" || tag == "R9") && eVt[31] ? tag :
            ((op == 2'd1 || op == 2'd2) ? "R11" : "R5");
    @(negedge clk);
    opI = op; vtypeI = vt; avlI = avl; rs1ZeroI = rs1z; rdZeroI = rdz;
    curVtypeI = cur; curVlI = curVl; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    chk({vtTag, " vtype"}, vtypeO, eVt);
    chk({tag, " vl"}, vlO, eVl);
    chk("R12 rd", rdDataO, eVl);
    chk("R2 valid/vstart", {validO, vstartClrO}, 2'b11);
    chk({tagB, " vl policy0"}, vlB, eVlB);
    heldVl = vlO;
    @(negedge clk);
    chk("R2 idle", {validO, vstartClrO, vlO}, {2'b00, heldVl});
  endtask

  initial begin
    longint m;
    logic [31:0] avls [8];
    repeat (3) @(negedge clk);
    chk("R1 reset", {validO, vstartClrO, vtypeO, vlO, rdDataO}, {2'b00, 32'h8000_0000, 8'h0, 32'h0});
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset hold", {validO, vtypeO, vlO}, {1'b0, 32'h8000_0000, 8'h0});

    // R3 R4 R5 R6 R7: full sweep of the low type byte
    for (int code = 0; code < 256; code++) begin
      m = vlmaxOf(code);
      if (m < 1) m = 4;
      avls[0] = 0; avls[1] = 1; avls[2] = 32'(m - 1); avls[3] = 32'(m);
      avls[4] = 32'(m + 1); avls[5] = 32'(2 * m - 1); avls[6] = 32'(2 * m);
      avls[7] = 32'hFFFF_FFFF;
      for (int k = 0; k < 8; k++)
        apply(2'd0, 32'(code), avls[k], 1'b0, 1'b0, 32'h0, 8'h0);
    end

    // R3: top bit set in register form and in the spare variant code
    apply(2'd0, 32'h8000_0008, 32'd5, 1'b0, 1'b0, 32'h0, 8'h0);
    apply(2'd3, 32'h8000_0010, 32'd5, 1'b0, 1'b0, 32'h0, 8'h0);
    // R11: upper garbage ignored in both immediate forms
    apply(2'd1, 32'hFFFF_F808, 32'd20, 1'b0, 1'b0, 32'h0, 8'h0);
    apply(2'd2, 32'h8000_0011, 32'd30, 1'b0, 1'b0, 32'h0, 8'h0);
    apply(2'd1, 32'h0000_0700, 32'd7, 1'b0, 1'b0, 32'h0, 8'h0);
    // R8: rs1 zero, rd not zero
    apply(2'd0, 32'h0000_0010, 32'd3, 1'b1, 1'b0, 32'h0, 8'h0);
    apply(2'd1, 32'h0000_0003, 32'd0, 1'b1, 1'b0, 32'h0, 8'h0);
    apply(2'd0, 32'h0000_0017, 32'd1, 1'b1, 1'b0, 32'h0, 8'h0);
    // R9: keep length, same ratio / different ratio / current vill
    apply(2'd0, 32'h0000_000F, 32'd9, 1'b1, 1'b1, 32'h0000_0010, 8'd5);
    apply(2'd1, 32'h0000_0010, 32'd9, 1'b1, 1'b1, 32'h0000_0010, 8'd7);
    apply(2'd0, 32'h0000_0008, 32'd9, 1'b1, 1'b1, 32'h0000_0010, 8'd5);
    apply(2'd0, 32'h0000_0000, 32'd9, 1'b1, 1'b1, 32'h8000_0000, 8'd5);
    apply(2'd0, 32'h0000_00C1, 32'd9, 1'b1, 1'b1, 32'h0000_0000, 8'd3);
    // R10: immediate-AVL form ignores the zero flags
    apply(2'd2, 32'h0000_0010, 32'd17, 1'b1, 1'b1, 32'h0000_0008, 8'd2);
    apply(2'd2, 32'h0000_0010, 32'd31, 1'b1, 1'b0, 32'h0, 8'h0);
    apply(2'd2, 32'h0000_0018, 32'd3, 1'b1, 1'b1, 32'h0000_0018, 8'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule